// File: doc/BRIEF.md
# Serial DAC Host Controller

This block is the host-side master for a chain of voltage-output serial converters that accept 16-bit words. A single-entry command port takes one of five requests: a plain word transfer, a transfer that updates the output at the end of the frame, a standalone update strobe, an output clear, and a readback of the converter's data register. The controller turns each request into pin activity. It divides the system clock into a serial clock that idles high, frames writes with an active-low frame select, and drives the load, clear and readback-enable sideband lines low for timed intervals.

Words leave MSB first. A new bit is presented on each rising serial-clock edge, so the bit is steady at the falling edge where the converter samples it. A readback holds the readback-enable line low for a 16-edge frame and collects the converter's serial output on each falling edge, MSB first. The collected word appears on `rd_data` in the same cycle as `done`. The serial clock divider and every minimum interval are parameters counted in system clock cycles.

Top module: `sdac_host_ctrl`

## Requirements
- R1: While `rst_n` is low, `sync_n`, `ldac_n`, `clr_n`, `rben_n` and `sclk` are high, and `busy` and `done` are low.
- R2: The opcode is `cmd_op`, with 0 = write, 1 = write-and-update, 2 = update strobe, 3 = clear, 4 = readback. A write frame drives `sync_n` low across exactly 16 falling `sclk` edges and sends `cmd_data` MSB first.
- R3: `sdin` changes only while `sclk` is high, so it is stable at every falling edge.
- R4: For write-and-update, `ldac_n` goes low before `sync_n` falls and returns high when `sync_n` rises. For a plain write, `ldac_n` stays high for the whole frame, so the converter output keeps its old value.
- R5: An update strobe drives `ldac_n` low for exactly `LDAC_CYC` cycles, and only while `sync_n` is high.
- R6: A clear drives `clr_n` low for exactly `CLR_CYC` cycles while every other control line stays high.
- R7: A readback drives `rben_n` low across 16 falling `sclk` edges, with `sync_n` held high. It captures `sdo` MSB first and returns the word on `rd_data` together with `done`.
- R8: Between the end of one frame and the start of the next, `sync_n` stays high for at least `SYNC_GAP` cycles.
- R9: A command is taken only while `busy` is low, and a command offered while `busy` is high has no effect. `done` lasts one cycle, in the cycle that `busy` falls.
- R10: Opcodes 5 to 7 cause no pin activity. `busy` does not rise for them, and `done` pulses in the next cycle.
- R11: `sclk` idles high and toggles only while `sync_n` or `rben_n` is low. Each frame has 16 falling edges, and strobe and clear commands have none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Command opcode |
| cmd_data | input | WORD_W | Word to send for write commands |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | WORD_W | Word captured by the last readback |
| sclk | output | 1 | Serial clock, idles high |
| sdin | output | 1 | Serial data to the converter |
| sync_n | output | 1 | Active-low write frame select |
| ldac_n | output | 1 | Active-low output load |
| clr_n | output | 1 | Active-low output clear |
| rben_n | output | 1 | Active-low readback enable |
| sdo | input | 1 | Serial data from the converter |

## Verification
The assertions assume that `cmd_op` and `cmd_data` are steady whenever `cmd_valid` is high, and that `sdo` changes only after a rising `sclk` edge, as a converter that shifts its register out would do. The bench meets both conditions. It drives command inputs only on falling system-clock edges, and its converter model shifts the readback word on each rising serial-clock edge, so the value captured at the falling edge is always settled. The reset state is checked while reset is held, before any stimulus is applied.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

   typedef enum logic [2:0] {
      OP_WRITE     = 3'd0,
      OP_WRITE_UPD = 3'd1,
      OP_STROBE    = 3'd2,
      OP_CLEAR     = 3'd3,
      OP_READ      = 3'd4
   } sdac_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_SETUP,
      ST_SHIFT,
      ST_HOLD,
      ST_GAP,
      ST_PULSE
   } sdac_state_e;

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/sdac_tick_gen.sv
module sdac_tick_gen #(
   parameter int unsigned DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);

   generate
      if (DIV <= 1) begin : g_every
         assign tick = en;
      end else begin : g_count
         localparam int unsigned CW = $clog2(DIV);
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (!en) begin
               cnt <= '0;
            end else if (cnt == LAST) begin
               cnt <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end

         assign tick = en && (cnt == LAST);
      end
   endgenerate

endmodule

// File: rtl/sdac_shift_reg.sv
module sdac_shift_reg #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         shift,
   input  logic         ser_in,
   output logic [W-1:0] par_out,
   output logic         msb
);

   logic [W-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh <= '0;
      end else if (load) begin
         sh <= load_val;
      end else if (shift) begin
         sh <= {sh[W-2:0], ser_in};
      end
   end

   assign par_out = sh;
   assign msb     = sh[W-1];

endmodule

// File: rtl/sdac_countdown.sv
module sdac_countdown #(
   parameter int unsigned CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] len,
   output logic          last
);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= (len == '0) ? '0 : len - 1'b1;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign last = (cnt == '0);

endmodule

// File: rtl/sdac_host_ctrl.sv
module sdac_host_ctrl
   import sdac_pkg::*;
#(
   parameter int unsigned WORD_W   = 16,
   parameter int unsigned HALF_DIV = 2,
   parameter int unsigned SYNC_GAP = 6,
   parameter int unsigned LDAC_CYC = 4,
   parameter int unsigned CLR_CYC  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [WORD_W-1:0] cmd_data,
   output logic              busy,
   output logic              done,
   output logic [WORD_W-1:0] rd_data,
   output logic              sclk,
   output logic              sdin,
   output logic              sync_n,
   output logic              ldac_n,
   output logic              clr_n,
   output logic              rben_n,
   input  logic              sdo
);

   localparam int unsigned EDGE_W = $clog2(WORD_W + 1);
   localparam int unsigned TMAX   = max3(SYNC_GAP, LDAC_CYC, CLR_CYC);
   localparam int unsigned TW     = $clog2(TMAX + 1);
   localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(WORD_W);

   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("sdac_host_ctrl: WORD_W must be at least 2");
      end
      if (HALF_DIV < 1) begin : g_bad_div
         $error("sdac_host_ctrl: HALF_DIV must be at least 1");
      end
      if (SYNC_GAP < 1 || LDAC_CYC < 1 || CLR_CYC < 1) begin : g_bad_time
         $error("sdac_host_ctrl: timing intervals must be at least 1");
      end
   endgenerate

   sdac_state_e       state;
   logic [2:0]        op_q;
   logic              sclk_q, sync_q, ldac_q, clr_q, rben_q;
   logic              busy_q, done_q;
   logic [WORD_W-1:0] rd_q;
   logic [EDGE_W-1:0] edges;

   logic              tick_en, tick;
   logic              is_read, fall_now, rise_now;
   logic              accept, acc_write, acc_read, acc_pulse;
   logic              sh_load, sh_shift;
   logic [WORD_W-1:0] sh_val, sh_par;
   logic              sh_msb;
   logic              tm_load, tm_last;
   logic [TW-1:0]     tm_len;

   assign accept    = cmd_valid && (state == ST_IDLE);
   assign acc_write = accept && (cmd_op == OP_WRITE || cmd_op == OP_WRITE_UPD);
   assign acc_read  = accept && (cmd_op == OP_READ);
   assign acc_pulse = accept && (cmd_op == OP_STROBE || cmd_op == OP_CLEAR);

   assign tick_en  = (state == ST_PRE) || (state == ST_SETUP) ||
                     (state == ST_SHIFT) || (state == ST_HOLD);
   assign is_read  = (op_q == OP_READ);
   assign fall_now = tick && ((state == ST_SETUP) || (state == ST_SHIFT && sclk_q));
   assign rise_now = tick && (state == ST_SHIFT) && !sclk_q;

   sdac_tick_gen #(.DIV(HALF_DIV)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (tick_en),
      .tick (tick)
   );

   // writes shift out after each rising edge; readbacks shift in on each falling edge
   assign sh_load  = acc_write || acc_read;
   assign sh_val   = acc_write ? cmd_data : '0;
   assign sh_shift = is_read ? fall_now : rise_now;

   sdac_shift_reg #(.W(WORD_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (sh_load),
      .load_val(sh_val),
      .shift   (sh_shift),
      .ser_in  (sdo),
      .par_out (sh_par),
      .msb     (sh_msb)
   );

   assign tm_load = acc_pulse || (state == ST_HOLD && tick);

   always_comb begin
      if (state == ST_HOLD) begin
         tm_len = TW'(SYNC_GAP);
      end else if (cmd_op == OP_STROBE) begin
         tm_len = TW'(LDAC_CYC);
      end else begin
         tm_len = TW'(CLR_CYC);
      end
   end

   sdac_countdown #(.CW(TW)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .load (tm_load),
      .len  (tm_len),
      .last (tm_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         op_q   <= '0;
         sclk_q <= 1'b1;
         sync_q <= 1'b1;
         ldac_q <= 1'b1;
         clr_q  <= 1'b1;
         rben_q <= 1'b1;
         busy_q <= 1'b0;
         done_q <= 1'b0;
         rd_q   <= '0;
         edges  <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (cmd_valid) begin
                  op_q <= cmd_op;
                  case (cmd_op)
                     OP_WRITE, OP_WRITE_UPD: begin
                        busy_q <= 1'b1;
                        ldac_q <= (cmd_op != OP_WRITE_UPD);
                        state  <= ST_PRE;
                     end
                     OP_READ: begin
                        busy_q <= 1'b1;
                        rben_q <= 1'b0;
                        state  <= ST_SETUP;
                     end
                     OP_STROBE: begin
                        busy_q <= 1'b1;
                        ldac_q <= 1'b0;
                        state  <= ST_PULSE;
                     end
                     OP_CLEAR: begin
                        busy_q <= 1'b1;
                        clr_q  <= 1'b0;
                        state  <= ST_PULSE;
                     end
                     default: begin
                        done_q <= 1'b1;
                     end
                  endcase
               end
            end
            ST_PRE: begin
               if (tick) begin
                  sync_q <= 1'b0;
                  state  <= ST_SETUP;
               end
            end
            ST_SETUP: begin
               if (tick) begin
                  sclk_q <= 1'b0;
                  edges  <= EDGE_W'(1);
                  state  <= ST_SHIFT;
               end
            end
            ST_SHIFT: begin
               if (tick) begin
                  if (sclk_q) begin
                     sclk_q <= 1'b0;
                     edges  <= edges + 1'b1;
                  end else begin
                     sclk_q <= 1'b1;
                     if (edges == LAST_EDGE) begin
                        state <= ST_HOLD;
                     end
                  end
               end
            end
            ST_HOLD: begin
               if (tick) begin
                  sync_q <= 1'b1;
                  rben_q <= 1'b1;
                  ldac_q <= 1'b1;
                  if (is_read) begin
                     rd_q <= sh_par;
                  end
                  state <= ST_GAP;
               end
            end
            ST_GAP: begin
               if (tm_last) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
                  state  <= ST_IDLE;
               end
            end
            ST_PULSE: begin
               if (tm_last) begin
                  ldac_q <= 1'b1;
                  clr_q  <= 1'b1;
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
                  state  <= ST_IDLE;
               end
            end
            default: begin
               state <= ST_IDLE;
            end
         endcase
      end
   end

   assign busy    = busy_q;
   assign done    = done_q;
   assign rd_data = rd_q;
   assign sclk    = sclk_q;
   assign sync_n  = sync_q;
   assign ldac_n  = ldac_q;
   assign clr_n   = clr_q;
   assign rben_n  = rben_q;
   assign sdin    = sync_q ? 1'b0 : sh_msb;

endmodule

// File: rtl/sdac_host_ctrl_chk.sv
module sdac_host_ctrl_chk #(
   parameter int unsigned SYNC_GAP = 6
) (
   input logic clk,
   input logic rst_n,
   input logic cmd_valid,
   input logic busy,
   input logic done,
   input logic sclk,
   input logic sdin,
   input logic sync_n,
   input logic ldac_n,
   input logic clr_n,
   input logic rben_n
);

   localparam int unsigned GW = $clog2(SYNC_GAP + 1) + 1;
   localparam logic [GW-1:0] GAP_SAT = GW'(SYNC_GAP);

   logic [GW-1:0] hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt <= GAP_SAT;
      end else if (!sync_n) begin
         hi_cnt <= '0;
      end else if (hi_cnt != GAP_SAT) begin
         hi_cnt <= hi_cnt + 1'b1;
      end
   end

   AST_RESET_IDLE: assert property (@(posedge clk)
      !rst_n |=> (sync_n && ldac_n && clr_n && rben_n && sclk && !busy && !done)); // R1
   AST_SDIN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!sclk && $past(!sclk)) |-> $stable(sdin)); // R3
   AST_LDAC_FRAME_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_n && $past(!sync_n)) |-> $stable(ldac_n)); // R4
   AST_STROBE_SYNC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ldac_n) |-> sync_n); // R5
   AST_CLR_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |-> (sync_n && rben_n && ldac_n)); // R6
   AST_NO_FRAME_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      !(!sync_n && !rben_n)); // R7
   AST_SYNC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sync_n) |-> (hi_cnt >= GAP_SAT)); // R8
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9
   AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done); // R9
   AST_BUSY_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cmd_valid)); // R9
   AST_SCLK_FRAMED: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk != $past(sclk)) |-> (!sync_n || !rben_n)); // R11

endmodule

bind sdac_host_ctrl sdac_host_ctrl_chk #(.SYNC_GAP(SYNC_GAP)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cmd_valid(cmd_valid),
   .busy     (busy),
   .done     (done),
   .sclk     (sclk),
   .sdin     (sdin),
   .sync_n   (sync_n),
   .ldac_n   (ldac_n),
   .clr_n    (clr_n),
   .rben_n   (rben_n)
);

// File: tb/sdac_host_ctrl_test.sv
module sdac_host_ctrl_test;

   localparam int W        = 16;
   localparam int HALF_DIV = 2;
   localparam int SYNC_GAP = 6;
   localparam int LDAC_CYC = 4;
   localparam int CLR_CYC  = 5;

   typedef struct packed {
      logic [2:0]  op;
      logic [15:0] data;
      logic [15:0] exp_dac;
      logic [15:0] exp_rd;
   } vec_t;

   // op: 0 write, 1 write-and-update, 2 strobe, 3 clear, 4 readback
   localparam vec_t VECS [11] = '{
      '{3'd1, 16'h2ABC, 16'h2ABC, 16'h0000},
      '{3'd4, 16'h0000, 16'h2ABC, 16'h2ABC},
      '{3'd0, 16'h1357, 16'h2ABC, 16'h0000},
      '{3'd4, 16'h0000, 16'h2ABC, 16'h2ABC},
      '{3'd2, 16'h0000, 16'h1357, 16'h0000},
      '{3'd4, 16'h0000, 16'h1357, 16'h1357},
      '{3'd1, 16'hFFFF, 16'hFFFF, 16'h0000},
      '{3'd4, 16'h0000, 16'hFFFF, 16'h3FFF},
      '{3'd3, 16'h0000, 16'hFFFF, 16'h0000},
      '{3'd1, 16'h0001, 16'h0001, 16'h0000},
      '{3'd4, 16'h0000, 16'h0001, 16'h0001}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic [2:0] cmd_op = '0;
   logic [W-1:0] cmd_data = '0;
   logic busy, done, sclk, sdin, sync_n, ldac_n, clr_n, rben_n;
   logic [W-1:0] rd_data;
   logic sdo;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   sdac_host_ctrl #(
      .WORD_W(W), .HALF_DIV(HALF_DIV), .SYNC_GAP(SYNC_GAP),
      .LDAC_CYC(LDAC_CYC), .CLR_CYC(CLR_CYC)
   ) uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_data(cmd_data), .busy(busy), .done(done), .rd_data(rd_data),
      .sclk(sclk), .sdin(sdin), .sync_n(sync_n), .ldac_n(ldac_n),
      .clr_n(clr_n), .rben_n(rben_n), .sdo(sdo)
   );

   // converter model
   logic [15:0] rx_sh = '0, last_word = '0, in_latch = '0, dac_reg = '0, rb_sh = '0;
   int rx_cnt = 0, last_cnt = 0, frames = 0, sclk_falls = 0, activity = 0;
   logic ldac_at_fall = 1'b1;

   always @(negedge sync_n) begin
      rx_cnt = 0;
      ldac_at_fall = ldac_n;
   end
   always @(negedge sclk) begin
      sclk_falls++;
      if (sync_n === 1'b0) begin
         rx_sh = {rx_sh[14:0], sdin};
         rx_cnt++;
      end
   end
   always @(posedge sync_n) begin
      if (rst_n) begin
         frames++;
         last_word = rx_sh;
         last_cnt  = rx_cnt;
         in_latch  = rx_sh;
         if (ldac_at_fall === 1'b0) dac_reg = rx_sh;
      end
   end
   always @(negedge ldac_n) if (sync_n === 1'b1) dac_reg = in_latch;
   always @(negedge rben_n) rb_sh = {2'b00, dac_reg[13:0]};
   always @(posedge sclk) if (rben_n === 1'b0) rb_sh = {rb_sh[14:0], 1'b0};
   assign sdo = rb_sh[15];

   always @(negedge sync_n or negedge ldac_n or negedge clr_n or negedge rben_n or negedge sclk)
      activity++;

   // width monitors
   int ldac_run = 0, ldac_last = 0, clr_run = 0, clr_last = 0, hi_run = 0, last_gap = 0;
   always @(posedge clk) begin
      if (ldac_n === 1'b0) ldac_run <= ldac_run + 1;
      else begin
         if (ldac_run != 0) ldac_last <= ldac_run;
         ldac_run <= 0;
      end
      if (clr_n === 1'b0) clr_run <= clr_run + 1;
      else begin
         if (clr_run != 0) clr_last <= clr_run;
         clr_run <= 0;
      end
      if (sync_n === 1'b1) hi_run <= hi_run + 1;
      else begin
         if (hi_run != 0) last_gap <= hi_run;
         hi_run <= 0;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic run_cmd(input logic [2:0] op, input logic [15:0] data,
                          output logic [15:0] rd, output int waited);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op    = op;
      cmd_data  = data;
      @(negedge clk);
      cmd_valid = 1'b0;
      waited = 0;
      while (!done && waited < 2000) begin
         @(negedge clk);
         waited++;
      end
      rd = rd_data;
      @(negedge clk);
      chk(done == 1'b0, "R9 done single cycle", done, 0);
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] rd;
      int waited, f0, s0, a0;
      repeat (3) @(negedge clk);
      chk({sync_n, ldac_n, clr_n, rben_n, sclk} == 5'b11111, "R1 idle pins in reset",
          {sync_n, ldac_n, clr_n, rben_n, sclk}, 5'b11111);
      chk({busy, done} == 2'b00, "R1 busy/done in reset", {busy, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // table of vectors
      foreach (VECS[i]) begin
         f0 = frames;
         s0 = sclk_falls;
         run_cmd(VECS[i].op, VECS[i].data, rd, waited);
         chk(waited < 2000, "R9 command completes", waited, 0);
         case (VECS[i].op)
            3'd0, 3'd1: begin
               chk(frames == f0 + 1, "R2 one write frame", frames - f0, 1);
               chk(last_word == VECS[i].data, "R2 word MSB first", last_word, VECS[i].data);
               chk(last_cnt == 16, "R2 16 falling edges in frame", last_cnt, 16);
               chk(ldac_at_fall == (VECS[i].op == 3'd0), "R4 ldac level at frame start",
                   ldac_at_fall, VECS[i].op == 3'd0);
               chk(dac_reg == VECS[i].exp_dac, "R4 output register", dac_reg, VECS[i].exp_dac);
               chk(sclk_falls == s0 + 16, "R11 sclk edges per write", sclk_falls - s0, 16);
            end
            3'd2: begin
               chk(ldac_last == LDAC_CYC, "R5 strobe width", ldac_last, LDAC_CYC);
               chk(dac_reg == VECS[i].exp_dac, "R5 strobe loads latch", dac_reg, VECS[i].exp_dac);
               chk(sclk_falls == s0, "R11 no sclk on strobe", sclk_falls - s0, 0);
            end
            3'd3: begin
               chk(clr_last == CLR_CYC, "R6 clear width", clr_last, CLR_CYC);
               chk(dac_reg == VECS[i].exp_dac, "R6 clear keeps register", dac_reg, VECS[i].exp_dac);
               chk(sclk_falls == s0, "R11 no sclk on clear", sclk_falls - s0, 0);
            end
            default: begin
               chk(rd == VECS[i].exp_rd, "R7 readback word", rd, VECS[i].exp_rd);
               chk(frames == f0, "R7 sync stays high", frames - f0, 0);
               chk(sclk_falls == s0 + 16, "R7 16 edges in readback", sclk_falls - s0, 16);
            end
         endcase
      end

      // R8: back-to-back frames keep the sync gap
      run_cmd(3'd0, 16'h0F0F, rd, waited);
      run_cmd(3'd0, 16'hF0F0, rd, waited);
      chk(last_gap >= SYNC_GAP, "R8 sync high gap", last_gap, SYNC_GAP);
      chk(last_word == 16'hF0F0, "R2 second back-to-back word", last_word, 16'hF0F0);

      // R9: command offered while busy is dropped
      f0 = frames;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 3'd1; cmd_data = 16'h0AAA;
      @(negedge clk);
      chk(busy == 1'b1, "R9 busy after accept", busy, 1);
      cmd_data = 16'h0555;
      repeat (3) @(negedge clk);
      cmd_valid = 1'b0;
      waited = 0;
      while (!done && waited < 2000) begin
         @(negedge clk);
         waited++;
      end
      repeat (100) @(negedge clk);
      chk(frames == f0 + 1, "R9 only one frame while busy", frames - f0, 1);
      chk(last_word == 16'h0AAA, "R9 first word kept", last_word, 16'h0AAA);

      // R10: reserved opcodes do nothing
      for (int op = 5; op < 8; op++) begin
         a0 = activity;
         @(negedge clk);
         cmd_valid = 1'b1; cmd_op = 3'(op); cmd_data = 16'hFFFF;
         @(negedge clk);
         cmd_valid = 1'b0;
         chk(done == 1'b1, "R10 done next cycle", done, 1);
         chk(busy == 1'b0, "R10 busy stays low", busy, 0);
         repeat (20) @(negedge clk);
         chk(activity == a0, "R10 no pin activity", activity - a0, 0);
      end

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule